// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Controller

This block sits on the controller side of a DDR3-class SDRAM interface. It owns the clock-enable (CKE) line. Each clock it receives one command request, the CKE level the requester wants for that edge, and three bank-status flags: some bank open, data burst in flight, and refresh in progress. From the CKE level registered at the previous edge, the requested level and the power state held just before the edge, it decides whether the request is a plain command, a power-down entry or exit, or a self-refresh entry or exit. It then drives CKE and the outgoing command.

A request that breaks the power-state rules is replaced by NOP on the command output and sets a sticky error flag. A CKE change asked for while the minimum CKE pulse width is still running is held back, and a same-cycle stall tells the requester to retry. Down-counters track the CKE minimum pulse, the power-down exit recovery, the self-refresh exit recovery, the read-after-self-refresh delay and the write-after-self-refresh delay. A refresh-debt counter keeps accruing while the device sits in power-down, so the scheduler can catch up after exit.

Top module: `ckepm_ctrl`

## Requirements
- R1: After reset `cke_out` is 1, `cmd_out` is NOP, `pstate` is IDLE, `illegal` is 0, `refresh_owed` is 0 and every recovery counter is clear.
- R2: When CKE was low at the previous edge and the request keeps it low, the power state and CKE are unchanged, `cmd_out` is NOP and the requested command is ignored without setting `illegal`.
- R3: A CKE change is accepted only with command NOP (0) or DESELECT (1), except REFRESH (6) falling into self-refresh. Any other command with a CKE change is rejected: CKE keeps its level, `cmd_out` is NOP and `illegal` is set.
- R4: An accepted power-down entry goes to ACT_PD when `bank_open` is 1 at that edge and to PRE_PD otherwise. Burst activity does not affect the choice.
- R5: REFRESH with CKE falling enters SELF_REFRESH only when `pstate` is IDLE and `bank_open`, `burst_busy` and `refresh_busy` are all 0. In any other case it is illegal.
- R6: An accepted self-refresh exit moves to SR_EXIT_WAIT. Only NOP or DESELECT is accepted on the T_XS-1 edges that follow. The state leaves SR_EXIT_WAIT at the first edge after that window, and any CKE-low request during SR_EXIT_WAIT is illegal.
- R7: After a self-refresh exit, READ (3) is illegal on the following T_XSDLL-1 edges and WRITE (4) is illegal on the following T_WR_SR-1 edges.
- R8: After a power-down exit, any command other than NOP or DESELECT is illegal on the following T_XP-1 edges.
- R9: After any accepted CKE transition, a request to change CKE on the next TCKE_MIN-1 edges raises `stall` in the same cycle, leaves CKE unchanged, puts NOP on `cmd_out` and does not set `illegal`.
- R10: `illegal` stays 1 until reset. A rejected command never reaches `cmd_out`, which shows NOP for that edge.
- R11: `refresh_owed` rises by one every T_REFI clocks, including in power-down, and saturates at DEBT_MAX. It falls by one when a REFRESH is forwarded with CKE high. It is cleared on self-refresh entry and held at 0 in SELF_REFRESH.
- R12: `pstate` encodes IDLE=0, ACTIVE=1, ACT_PD=2, PRE_PD=3, SELF_REFRESH=4, SR_EXIT_WAIT=5. With CKE high outside the exit window, it shows IDLE when the bank flags were all 0 and no exit-recovery counter was running before the edge, and ACTIVE otherwise. The command codes are ACT=2, PRE=5 and MRS=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd | input | 3 | Requested command code |
| req_cke | input | 1 | CKE level requested for this edge |
| bank_open | input | 1 | At least one bank is open |
| burst_busy | input | 1 | Read or write burst in flight |
| refresh_busy | input | 1 | Refresh cycle in progress |
| cke_out | output | 1 | Registered CKE to the device |
| cmd_out | output | 3 | Registered command to the device |
| stall | output | 1 | CKE change held back by the minimum-pulse rule |
| illegal | output | 1 | Sticky rule-violation flag |
| pstate | output | 3 | Encoded power state |
| refresh_owed | output | DEBT_W | Outstanding refresh count |

## Verification
The bound checker checks these properties on every clock:
- CKE-low holds leave the state alone and emit NOP.
- A stall freezes CKE and puts NOP on the command output.
- The error flag never clears.
- Power-down entries pick their flavour from `bank_open`.
- Self-refresh is entered only from IDLE with REFRESH.
- The exit window carries only NOP or DESELECT.
- The refresh debt stays in range.

The exact lengths of the recovery windows, the IDLE/ACTIVE reporting and the debt counting against elapsed time depend on whole histories. Only the bench scenarios, compared against its reference model, can show them.

// File: rtl/ckepm_pkg.sv
// Shared encodings for the CKE power-state controller.
// Assumes a 3-bit command bus and a 3-bit state report.
package ckepm_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_DES = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_PRE = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_ACTIVE   = 3'd1,
        PS_ACT_PD   = 3'd2,
        PS_PRE_PD   = 3'd3,
        PS_SELF_REF = 3'd4,
        PS_SR_EXIT  = 3'd5
    } pstate_e;

    // Timer slots, in the order used by the timer bank
    localparam int unsigned TM_HOLD   = 0;
    localparam int unsigned TM_XP     = 1;
    localparam int unsigned TM_XS     = 2;
    localparam int unsigned TM_XSDLL  = 3;
    localparam int unsigned TM_WRSR   = 4;
    localparam int unsigned TM_COUNT  = 5;

    // True for the two commands that are allowed around CKE changes
    function automatic logic is_quiet(cmd_e c);
        return (c == CMD_NOP) || (c == CMD_DES);
    endfunction

endpackage

// File: rtl/ckepm_timer.sv
// Reloadable down-counter for one recovery interval.
// On load it takes SPAN-1, so busy covers the SPAN-1 edges after the
// loading edge. SPAN must be at least 1.
module ckepm_timer #(
    parameter int unsigned SPAN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int unsigned W = (SPAN < 2) ? 1 : $clog2(SPAN);
    localparam logic [W-1:0] RELOAD = W'(SPAN - 1);

    logic [W-1:0] cnt;

    // Reload on the matching event, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= RELOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/ckepm_refdebt.sv
// Refresh-debt tracker. A free-running interval counter adds one owed
// refresh per period up to DEBT_MAX. Each forwarded REFRESH repays one.
// Self-refresh clears the debt, since the device refreshes itself there.
module ckepm_refdebt #(
    parameter int unsigned T_REFI   = 3120,
    parameter int unsigned DEBT_MAX = 8,
    localparam int unsigned DEBT_W  = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sr,
    input  logic              sr_entry,
    input  logic              ref_issued,
    output logic [DEBT_W-1:0] debt
);
    localparam int unsigned IW = (T_REFI < 2) ? 1 : $clog2(T_REFI);
    localparam logic [IW-1:0] IVL_LAST = IW'(T_REFI - 1);
    localparam logic [DEBT_W-1:0] DMAX = DEBT_W'(DEBT_MAX);

    logic [IW-1:0] ivl;
    logic          tick;
    logic          repay;

    assign tick  = (ivl == IVL_LAST);
    assign repay = ref_issued && (debt != '0);

    // Interval counter wraps once per refresh period
    always_ff @(posedge clk) begin
        if (!rst_n)     ivl <= '0;
        else if (tick)  ivl <= '0;
        else            ivl <= ivl + 1'b1;
    end

    // Debt accrues on each tick and is repaid by forwarded refreshes
    always_ff @(posedge clk) begin
        if (!rst_n)                  debt <= '0;
        else if (sr_entry || in_sr)  debt <= '0;
        else if (tick && !repay) begin
            if (debt != DMAX)        debt <= debt + 1'b1;
        end
        else if (repay && !tick)     debt <= debt - 1'b1;
    end

endmodule

// File: rtl/ckepm_fsm.sv
// Power-state decision logic and its registers.
// Each edge is judged from the registered CKE (previous edge), the
// requested CKE (this edge), the registered state and the busy flags of
// the recovery timers. It assumes the timers report busy for the
// edges on which their rule still applies.
module ckepm_fsm
    import ckepm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  cmd_e    req_cmd,
    input  logic    req_cke,
    input  logic    bank_open,
    input  logic    burst_busy,
    input  logic    refresh_busy,
    input  logic    hold_busy,
    input  logic    txp_busy,
    input  logic    txs_busy,
    input  logic    txsdll_busy,
    input  logic    wrsr_busy,
    output pstate_e state_q,
    output logic    cke_q,
    output cmd_e    cmd_q,
    output logic    illegal_q,
    output logic    stall,
    output logic    cke_evt,
    output logic    pd_exit,
    output logic    sr_exit,
    output logic    sr_entry,
    output logic    ref_issued
);
    pstate_e state_d;
    pstate_e hi_next;
    logic    cke_d;
    cmd_e    cmd_d;
    logic    flag;
    logic    quiet;
    logic    clean;
    logic    early_cmd;

    assign quiet = is_quiet(req_cmd);
    assign clean = !bank_open && !burst_busy && !refresh_busy;
    assign stall = (req_cke != cke_q) && hold_busy;

    // Commands blocked by an exit-recovery window while CKE stays high
    assign early_cmd = ((txs_busy || txp_busy) && !quiet)
                    || ((req_cmd == CMD_RD) && txsdll_busy)
                    || ((req_cmd == CMD_WR) && wrsr_busy);

    // State reached with CKE high when no CKE event happens
    always_comb begin
        if ((state_q == PS_SR_EXIT) && txs_busy)
            hi_next = PS_SR_EXIT;
        else if (clean && !txp_busy && !txs_busy)
            hi_next = PS_IDLE;
        else
            hi_next = PS_ACTIVE;
    end

    // Decide the outcome of this edge's request
    always_comb begin
        state_d    = cke_q ? hi_next : state_q;
        cke_d      = cke_q;
        cmd_d      = CMD_NOP;
        flag       = 1'b0;
        cke_evt    = 1'b0;
        pd_exit    = 1'b0;
        sr_exit    = 1'b0;
        sr_entry   = 1'b0;
        ref_issued = 1'b0;
        if (stall) begin
            // held back: nothing forwarded, no error
        end
        else if (!cke_q) begin
            if (req_cke) begin
                if (!quiet) begin
                    flag = 1'b1;
                end
                else begin
                    cke_d   = 1'b1;
                    cke_evt = 1'b1;
                    cmd_d   = req_cmd;
                    if (state_q == PS_SELF_REF) begin
                        state_d = PS_SR_EXIT;
                        sr_exit = 1'b1;
                    end
                    else begin
                        state_d = PS_ACTIVE;
                        pd_exit = 1'b1;
                    end
                end
            end
        end
        else if (!req_cke) begin
            if (state_q == PS_SR_EXIT) begin
                flag = 1'b1;
            end
            else if (quiet) begin
                cke_d   = 1'b0;
                cke_evt = 1'b1;
                cmd_d   = req_cmd;
                state_d = bank_open ? PS_ACT_PD : PS_PRE_PD;
            end
            else if ((req_cmd == CMD_REF) && (state_q == PS_IDLE) && clean) begin
                cke_d    = 1'b0;
                cke_evt  = 1'b1;
                cmd_d    = CMD_REF;
                state_d  = PS_SELF_REF;
                sr_entry = 1'b1;
            end
            else begin
                flag = 1'b1;
            end
        end
        else begin
            if (early_cmd) begin
                flag = 1'b1;
            end
            else begin
                cmd_d      = req_cmd;
                ref_issued = (req_cmd == CMD_REF);
            end
        end
    end

    // Register state, CKE, outgoing command and the sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PS_IDLE;
            cke_q     <= 1'b1;
            cmd_q     <= CMD_NOP;
            illegal_q <= 1'b0;
        end
        else begin
            state_q   <= state_d;
            cke_q     <= cke_d;
            cmd_q     <= cmd_d;
            illegal_q <= illegal_q || flag;
        end
    end

endmodule

// File: rtl/ckepm_ctrl.sv
// Top of the CKE power-state controller.
// It ties the decision logic to a bank of recovery timers and to the
// refresh-debt tracker. All timing parameters are in controller clocks,
// each at least 1. T_REFI must be at least 2.
module ckepm_ctrl
    import ckepm_pkg::*;
#(
    parameter int unsigned TCKE_MIN = 3,
    parameter int unsigned T_XP     = 4,
    parameter int unsigned T_XS     = 24,
    parameter int unsigned T_XSDLL  = 512,
    parameter int unsigned T_WR_SR  = 512,
    parameter int unsigned T_REFI   = 3120,
    parameter int unsigned DEBT_MAX = 8,
    localparam int unsigned DEBT_W  = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_cmd,
    input  logic              req_cke,
    input  logic              bank_open,
    input  logic              burst_busy,
    input  logic              refresh_busy,
    output logic              cke_out,
    output logic [2:0]        cmd_out,
    output logic              stall,
    output logic              illegal,
    output logic [2:0]        pstate,
    output logic [DEBT_W-1:0] refresh_owed
);
    localparam int unsigned SPANS [TM_COUNT] =
        '{TCKE_MIN, T_XP, T_XS, T_XSDLL, T_WR_SR};

    pstate_e             state_q;
    cmd_e                cmd_q;
    logic                cke_evt;
    logic                pd_exit;
    logic                sr_exit;
    logic                sr_entry;
    logic                ref_issued;
    logic [TM_COUNT-1:0] tm_load;
    logic [TM_COUNT-1:0] tm_busy;

    // Event that reloads each timer slot
    always_comb begin
        tm_load           = '0;
        tm_load[TM_HOLD]  = cke_evt;
        tm_load[TM_XP]    = pd_exit;
        tm_load[TM_XS]    = sr_exit;
        tm_load[TM_XSDLL] = sr_exit;
        tm_load[TM_WRSR]  = sr_exit;
    end

    for (genvar g = 0; g < TM_COUNT; g++) begin : g_tmr
        ckepm_timer #(.SPAN(SPANS[g])) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (tm_load[g]),
            .busy  (tm_busy[g])
        );
    end

    ckepm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_cmd      (cmd_e'(req_cmd)),
        .req_cke      (req_cke),
        .bank_open    (bank_open),
        .burst_busy   (burst_busy),
        .refresh_busy (refresh_busy),
        .hold_busy    (tm_busy[TM_HOLD]),
        .txp_busy     (tm_busy[TM_XP]),
        .txs_busy     (tm_busy[TM_XS]),
        .txsdll_busy  (tm_busy[TM_XSDLL]),
        .wrsr_busy    (tm_busy[TM_WRSR]),
        .state_q      (state_q),
        .cke_q        (cke_out),
        .cmd_q        (cmd_q),
        .illegal_q    (illegal),
        .stall        (stall),
        .cke_evt      (cke_evt),
        .pd_exit      (pd_exit),
        .sr_exit      (sr_exit),
        .sr_entry     (sr_entry),
        .ref_issued   (ref_issued)
    );

    ckepm_refdebt #(.T_REFI(T_REFI), .DEBT_MAX(DEBT_MAX)) u_debt (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_sr      (state_q == PS_SELF_REF),
        .sr_entry   (sr_entry),
        .ref_issued (ref_issued),
        .debt       (refresh_owed)
    );

    assign cmd_out = cmd_q;
    assign pstate  = state_q;

endmodule

// File: rtl/ckepm_ctrl_chk.sv
// Port-level property checker for ckepm_ctrl, attached by bind.
// Assumes the encodings of ckepm_pkg.
module ckepm_ctrl_chk #(
    parameter int unsigned DEBT_MAX = 8,
    parameter int unsigned DEBT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_cke,
    input logic              bank_open,
    input logic              cke_out,
    input logic [2:0]        cmd_out,
    input logic              stall,
    input logic              illegal,
    input logic [2:0]        pstate,
    input logic [DEBT_W-1:0] refresh_owed
);
    import ckepm_pkg::*;

    // R2
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_out && !req_cke) |=> (!cke_out && cmd_out == CMD_NOP && $stable(pstate)));

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(cke_out) && cmd_out == CMD_NOP));

    // R10
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    // R3
    fall_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_out) |-> (cmd_out == CMD_NOP || cmd_out == CMD_DES || cmd_out == CMD_REF));

    // R4
    pre_pd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_PRE_PD && $past(cke_out)) |-> !$past(bank_open));

    // R4
    act_pd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_ACT_PD && $past(cke_out)) |-> $past(bank_open));

    // R5
    sr_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_SELF_REF && $past(cke_out)) |-> ($past(pstate) == PS_IDLE && cmd_out == CMD_REF));

    // R6
    exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_SR_EXIT) |-> (cmd_out == CMD_NOP || cmd_out == CMD_DES));

    // R11
    debt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_owed <= DEBT_W'(DEBT_MAX));

    // R11
    debt_sr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_SELF_REF) |-> (refresh_owed == '0));

endmodule

bind ckepm_ctrl ckepm_ctrl_chk #(.DEBT_MAX(DEBT_MAX), .DEBT_W(DEBT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_cke      (req_cke),
    .bank_open    (bank_open),
    .cke_out      (cke_out),
    .cmd_out      (cmd_out),
    .stall        (stall),
    .illegal      (illegal),
    .pstate       (pstate),
    .refresh_owed (refresh_owed)
);

// File: tb/tb_ckepm_ctrl.sv
// Bench for ckepm_ctrl: directed scenarios plus seeded random traffic,
// compared every cycle against a reference model built from the brief.
module tb_ckepm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P_CKE  = 3;
    localparam int P_XP   = 3;
    localparam int P_XS   = 5;
    localparam int P_DLL  = 8;
    localparam int P_WR   = 12;
    localparam int P_REFI = 20;
    localparam int P_DMAX = 7;
    localparam int DW     = $clog2(P_DMAX + 1);

    localparam logic [2:0] NOP = 3'd0, DES = 3'd1, ACT = 3'd2, RD = 3'd3,
                           WR = 3'd4, PRE = 3'd5, REF = 3'd6, MRS = 3'd7;
    localparam int S_IDLE = 0, S_ACT = 1, S_APD = 2, S_PPD = 3, S_SR = 4, S_SRX = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    req_cmd = NOP;
    logic          req_cke = 1'b1;
    logic          bank_open = 1'b0, burst_busy = 1'b0, refresh_busy = 1'b0;
    logic          cke_out, stall, illegal;
    logic [2:0]    cmd_out, pstate;
    logic [DW-1:0] refresh_owed;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int m_state, m_cke, m_cmd, m_ill, m_debt, m_ivl;
    int m_hold, m_xp, m_xs, m_dll, m_wr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckepm_ctrl #(.TCKE_MIN(P_CKE), .T_XP(P_XP), .T_XS(P_XS), .T_XSDLL(P_DLL),
                 .T_WR_SR(P_WR), .T_REFI(P_REFI), .DEBT_MAX(P_DMAX)) dut (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_cke(req_cke),
        .bank_open(bank_open), .burst_busy(burst_busy), .refresh_busy(refresh_busy),
        .cke_out(cke_out), .cmd_out(cmd_out), .stall(stall), .illegal(illegal),
        .pstate(pstate), .refresh_owed(refresh_owed));

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int dec(int v);
        return (v > 0) ? v - 1 : 0;
    endfunction

    // Advance the model by one edge from the current inputs
    task automatic model_edge();
        bit quiet, clean, stl, flag, evt, pdx, srx, sre, refi, tick, rep;
        int hi, n_state, n_cke, n_cmd;
        quiet = (req_cmd == NOP) || (req_cmd == DES);
        clean = !bank_open && !burst_busy && !refresh_busy;
        stl   = (int'(req_cke) != m_cke) && (m_hold != 0);
        if (m_state == S_SRX && m_xs != 0) hi = S_SRX;
        else if (clean && m_xp == 0 && m_xs == 0) hi = S_IDLE;
        else hi = S_ACT;
        n_state = m_cke ? hi : m_state;
        n_cke = m_cke; n_cmd = NOP;
        flag = 0; evt = 0; pdx = 0; srx = 0; sre = 0; refi = 0;
        if (stl) begin
        end else if (m_cke == 0) begin
            if (req_cke) begin
                if (!quiet) flag = 1;
                else begin
                    n_cke = 1; evt = 1; n_cmd = req_cmd;
                    if (m_state == S_SR) begin n_state = S_SRX; srx = 1; end
                    else begin n_state = S_ACT; pdx = 1; end
                end
            end
        end else if (!req_cke) begin
            if (m_state == S_SRX) flag = 1;
            else if (quiet) begin
                n_cke = 0; evt = 1; n_cmd = req_cmd;
                n_state = bank_open ? S_APD : S_PPD;
            end else if (req_cmd == REF && m_state == S_IDLE && clean) begin
                n_cke = 0; evt = 1; n_cmd = REF; n_state = S_SR; sre = 1;
            end else flag = 1;
        end else begin
            if (((m_xs != 0 || m_xp != 0) && !quiet) || (req_cmd == RD && m_dll != 0)
                || (req_cmd == WR && m_wr != 0)) flag = 1;
            else begin n_cmd = req_cmd; refi = (req_cmd == REF); end
        end
        tick = (m_ivl == P_REFI - 1);
        rep  = refi && (m_debt != 0);
        if (sre || m_state == S_SR) m_debt = 0;
        else if (tick && !rep) m_debt = (m_debt < P_DMAX) ? m_debt + 1 : m_debt;
        else if (rep && !tick) m_debt = m_debt - 1;
        m_ivl  = tick ? 0 : m_ivl + 1;
        m_hold = evt ? P_CKE - 1 : dec(m_hold);
        m_xp   = pdx ? P_XP - 1 : dec(m_xp);
        m_xs   = srx ? P_XS - 1 : dec(m_xs);
        m_dll  = srx ? P_DLL - 1 : dec(m_dll);
        m_wr   = srx ? P_WR - 1 : dec(m_wr);
        m_state = n_state; m_cke = n_cke; m_cmd = n_cmd;
        m_ill = m_ill | int'(flag);
    endtask

    task automatic compare_outputs(string tag);
        check({tag, "/R3"},  "cke_out", int'(cke_out), m_cke);
        check({tag, "/R10"}, "cmd_out", int'(cmd_out), m_cmd);
        check({tag, "/R12"}, "pstate", int'(pstate), m_state);
        check({tag, "/R10"}, "illegal", int'(illegal), m_ill);
        check({tag, "/R11"}, "refresh_owed", int'(refresh_owed), m_debt);
    endtask

    // One cycle: drive at the falling edge, check stall, then registered outputs
    task automatic step(string tag, logic [2:0] c, logic k, logic bo, logic bb, logic rb);
        req_cmd = c; req_cke = k; bank_open = bo; burst_busy = bb; refresh_busy = rb;
        #1;
        check({tag, "/R9"}, "stall", int'(stall), int'((int'(k) != m_cke) && (m_hold != 0)));
        model_edge();
        @(posedge clk); #1;
        compare_outputs(tag);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_cmd = NOP; req_cke = 1'b1;
        bank_open = 0; burst_busy = 0; refresh_busy = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_state = S_IDLE; m_cke = 1; m_cmd = NOP; m_ill = 0; m_debt = 0; m_ivl = 0;
        m_hold = 0; m_xp = 0; m_xs = 0; m_dll = 0; m_wr = 0;
        // R1 reset state
        check("R1", "cke_out", int'(cke_out), 1);
        check("R1", "cmd_out", int'(cmd_out), NOP);
        check("R1", "pstate", int'(pstate), S_IDLE);
        check("R1", "illegal", int'(illegal), 0);
        check("R1", "refresh_owed", int'(refresh_owed), 0);
    endtask

    task automatic idle_cycles(string tag, int n, logic k);
        for (int i = 0; i < n; i++) step(tag, NOP, k, 0, 0, 0);
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'd4242);
        @(negedge clk);

        // R4 active power-down, R9 stall, R2 ignored command, R8 exit recovery
        do_reset();
        step("R4", ACT, 1, 1, 0, 0);
        step("R4", NOP, 0, 1, 0, 0);
        check("R4", "pstate is ACT_PD", int'(pstate), S_APD);
        step("R9", NOP, 1, 1, 0, 0);
        check("R9", "cke held low", int'(cke_out), 0);
        step("R2", RD, 0, 1, 0, 0);
        check("R2", "ignored cmd", int'(cmd_out), NOP);
        step("R8", DES, 1, 1, 0, 0);
        step("R8", RD, 1, 1, 0, 0);
        check("R8", "read during tXP flagged", int'(illegal), 1);

        // R4 precharge power-down with burst, R3 bad exit command
        do_reset();
        step("R4", DES, 0, 0, 1, 0);
        check("R4", "pstate is PRE_PD", int'(pstate), S_PPD);
        idle_cycles("R2", 3, 0);
        step("R3", ACT, 1, 0, 0, 0);
        check("R3", "exit rejected", int'(cke_out), 0);

        // R5 self-refresh refused when not idle
        do_reset();
        step("R5", REF, 0, 1, 0, 0);
        check("R5", "refused entry", int'(illegal), 1);

        // R5 R6 R7 R11 self-refresh round trip with debt clear
        do_reset();
        idle_cycles("R11", 25, 1);
        check("R11", "debt accrued", int'(refresh_owed), 1);
        step("R5", REF, 0, 0, 0, 0);
        check("R5", "in self refresh", int'(pstate), S_SR);
        idle_cycles("R11", 30, 0);
        step("R6", NOP, 1, 0, 0, 0);
        check("R6", "exit wait", int'(pstate), S_SRX);
        idle_cycles("R6", P_XS - 1, 1);
        step("R7", WR, 1, 0, 0, 0);
        check("R7", "early write flagged", int'(illegal), 1);

        // R6 command inside exit window
        do_reset();
        idle_cycles("R6", 2, 1);
        step("R6", REF, 0, 0, 0, 0);
        idle_cycles("R6", P_CKE, 0);
        step("R6", NOP, 1, 0, 0, 0);
        step("R6", PRE, 1, 0, 0, 0);
        check("R6", "cmd in tXS flagged", int'(illegal), 1);

        // R7 read after tXSDLL is accepted
        do_reset();
        idle_cycles("R7", 2, 1);
        step("R7", REF, 0, 0, 0, 0);
        idle_cycles("R7", P_CKE, 0);
        step("R7", DES, 1, 0, 0, 0);
        idle_cycles("R7", P_DLL - 1, 1);
        step("R7", RD, 1, 0, 0, 0);
        check("R7", "read forwarded", int'(cmd_out), RD);
        check("R7", "no error", int'(illegal), 0);

        // R11 debt saturates in power-down, then refreshes repay it
        do_reset();
        step("R11", NOP, 0, 0, 0, 0);
        idle_cycles("R11", P_REFI * (P_DMAX + 2), 0);
        check("R11", "debt saturated", int'(refresh_owed), P_DMAX);
        step("R11", NOP, 1, 0, 0, 0);
        idle_cycles("R11", P_XP, 1);
        step("R11", REF, 1, 0, 0, 0);
        step("R12", NOP, 1, 0, 0, 0);
        check("R12", "idle after recovery", int'(pstate), S_IDLE);

        // Random traffic, reset every 100 cycles
        for (int b = 0; b < 20; b++) begin
            do_reset();
            for (int i = 0; i < 100; i++) begin
                logic [2:0] c;
                logic k, bo, bb, rb;
                c  = ($urandom % 2 == 0) ? 3'(($urandom % 2)) : 3'($urandom % 8);
                k  = ($urandom % 4 == 0) ? logic'(m_cke == 0) : logic'(m_cke != 0);
                bo = ($urandom % 3 == 0);
                bb = ($urandom % 5 == 0);
                rb = ($urandom % 6 == 0);
                step("RND", c, k, bo, bb, rb);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule